// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Initiator

This block is the host side of one port on a memory that shares a single set of pins between address and data. A client hands it one access at a time over a valid/ready request channel. Each request carries an address, a read/write flag and write data. The block then runs the full bus cycle on the pins: a chip-enable strobe (`mem_ce_n`), an output-enable strobe (`mem_oe_n`) and a write strobe (`mem_we_n`), all active low. The shared lines are presented as three separate signals: a drive value, a drive enable and an input sample.

Every minimum interval of the bus is given as a nanosecond parameter. The block converts each one to whole clock cycles, rounding up, and never uses fewer than one cycle. The intervals are:

- address setup before the enable falls;
- address hold after it falls;
- enable-to-strobe delay;
- read access time;
- write pulse width;
- write data hold;
- recovery gap between cycles.

A read ends with the sampled byte and a one-cycle response pulse. A write ends with the same pulse, used as an acknowledge.

The sequencer has nine states:

| State | Pins | Leaves when the phase timer expires, to |
|---|---|---|
| IDLE | ready high | ADDR_SETUP, when a request is present |
| ADDR_SETUP | address driven, enable high | ADDR_HOLD |
| ADDR_HOLD | enable low, address still driven | RD_TURN for a read, WR_SETUP for a write |
| RD_TURN | bus released | RD_STROBE |
| RD_STROBE | output enable low | RECOVER |
| WR_SETUP | write data driven | WR_STROBE |
| WR_STROBE | write enable low | WR_HOLD |
| WR_HOLD | both strobes high, data still driven | RECOVER |
| RECOVER | all strobes high, bus released | IDLE |

Top module: `mbus_cycle_ctrl`

## Requirements
- R1: While reset is held, `req_ready` is 1, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_ad_oe` is 0 and `rsp_valid` is 0.
- R2: The address is driven (`mem_ad_oe` = 1, `mem_ad_out` = request address) for at least ceil(T_AS_NS/CLK_NS) cycles, minimum 1, before `mem_ce_n` falls.
- R3: The address stays driven for at least ceil(T_AH_NS/CLK_NS) cycles, counted from the cycle in which `mem_ce_n` falls.
- R4: `mem_ce_n` has been low for at least ceil(T_COE_NS/CLK_NS) cycles when `mem_oe_n` or `mem_we_n` falls.
- R5: For a read, the host drive enable is 0 in the cycle before `mem_oe_n` falls, and stays 0 while `mem_oe_n` is low.
- R6: For a read, `mem_oe_n` is low for exactly ceil(T_OEA_NS/CLK_NS) cycles. `mem_ad_in` is sampled on the last of those cycles. `mem_ce_n` and `mem_oe_n` rise on the same edge. In the cycle after that edge, `rsp_valid` is 1 for exactly one cycle and `rsp_rdata` holds the sampled byte.
- R7: For a write, data is driven when `mem_we_n` falls. `mem_we_n` stays low for at least ceil(T_WP_NS/CLK_NS) cycles. The data remains driven for at least ceil(T_DH_NS/CLK_NS) cycles after `mem_we_n` and `mem_ce_n` rise together.
- R8: Between consecutive cycles, all three strobes are high for at least ceil(T_REC_NS/CLK_NS) cycles before `mem_ce_n` falls again.
- R9: `mem_we_n` stays 1 whenever `mem_oe_n` is 0, and `mem_oe_n` stays 1 whenever `mem_we_n` is 0.
- R10: `req_ready` is 1 only in IDLE. A request is accepted on an edge where `req_valid` and `req_ready` are both 1. `req_ready` is then 0 for exactly AS+AH+GAP+OEA+REC cycles after a read, or AS+AH+GAP+WP+DH+REC cycles after a write. Here GAP = max(COE-AH, 1). Requests presented while busy are ignored and produce no response.
- R11: For a write, `rsp_valid` is 1 for one cycle, in the cycle after `mem_we_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | BUS_W | Target address |
| req_wdata | input | BUS_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | BUS_W | Byte sampled by the last read |
| mem_ce_n | output | 1 | Port enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ad_out | output | BUS_W | Value the host drives on the shared lines |
| mem_ad_oe | output | 1 | Host drive enable for the shared lines |
| mem_ad_in | input | BUS_W | Value seen on the shared lines |

## Verification
The hardest situation to reach from the ports is the one where a request waits on a busy controller. A valid request with a different address and direction is presented while a cycle is still running, so it must be ignored and leave no trace. The driver holds `req_valid` high for two cycles right after each acceptance, with a complemented address and an inverted direction. The scoreboard then flags any extra response, and the memory model flags any stray enable or write.

A second hard case is a write whose data equals its address, so the hold and data phases look alike on the lines. The bench reaches it by writing address 0x42 with data 0x42.

The memory model drives the poison value 0xEE whenever it is not selected. A sample taken one cycle early or late therefore shows up as a wrong read byte.

// File: rtl/mbus_cyc_pkg.sv
package mbus_cyc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR_SETUP,
        ST_ADDR_HOLD,
        ST_RD_TURN,
        ST_RD_STROBE,
        ST_WR_SETUP,
        ST_WR_STROBE,
        ST_WR_HOLD,
        ST_RECOVER
    } phase_e;

    // Round a nanosecond minimum up to whole clocks, never below one clock.
    function automatic int ns_to_cyc(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mbus_phase_timer.sv
module mbus_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= len - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign last = (cnt_q == '0);

    // R2
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (len != '0))
        else $error("phase started with zero length");

endmodule

// File: rtl/mbus_rd_capture.sv
module mbus_rd_capture #(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_done,
    input  logic             wr_done,
    input  logic [BUS_W-1:0] bus_in,
    output logic             rsp_valid,
    output logic [BUS_W-1:0] rsp_rdata
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_done | wr_done;
            if (rd_done) rsp_rdata <= bus_in;
        end
    end

    // R6
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid)
        else $error("response pulse longer than one cycle");

    // R6
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_done && wr_done))
        else $error("read and write completed together");

endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
    import mbus_cyc_pkg::*;
#(
    parameter int BUS_W   = 8,
    parameter int CNT_W   = 4,
    parameter int AS_CYC  = 1,
    parameter int AH_CYC  = 3,
    parameter int GAP_CYC = 1,
    parameter int COE_CYC = 3,
    parameter int OEA_CYC = 5,
    parameter int WP_CYC  = 5,
    parameter int DH_CYC  = 1,
    parameter int REC_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [BUS_W-1:0] req_addr,
    input  logic [BUS_W-1:0] req_wdata,
    output logic             req_ready,
    input  logic             timer_last,
    output logic             timer_start,
    output logic [CNT_W-1:0] timer_len,
    output logic             rd_done,
    output logic             wr_done,
    output logic             ce_n,
    output logic             oe_n,
    output logic             we_n,
    output logic [BUS_W-1:0] ad_out,
    output logic             ad_drv
);

    phase_e state_q, state_d;

    logic             wr_q;
    logic [BUS_W-1:0] addr_q, wdata_q, nxt_addr;
    logic             accept;

    logic             ce_n_d, oe_n_d, we_n_d, drv_d;
    logic [BUS_W-1:0] out_d;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign nxt_addr  = accept ? req_addr : addr_q;

    // Request capture at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            wr_q    <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (req_valid)  state_d = ST_ADDR_SETUP;
            ST_ADDR_SETUP: if (timer_last) state_d = ST_ADDR_HOLD;
            ST_ADDR_HOLD:  if (timer_last) state_d = wr_q ? ST_WR_SETUP : ST_RD_TURN;
            ST_RD_TURN:    if (timer_last) state_d = ST_RD_STROBE;
            ST_RD_STROBE:  if (timer_last) state_d = ST_RECOVER;
            ST_WR_SETUP:   if (timer_last) state_d = ST_WR_STROBE;
            ST_WR_STROBE:  if (timer_last) state_d = ST_WR_HOLD;
            ST_WR_HOLD:    if (timer_last) state_d = ST_RECOVER;
            ST_RECOVER:    if (timer_last) state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Phase length for the state being entered.
    always_comb begin
        unique case (state_d)
            ST_ADDR_SETUP: timer_len = CNT_W'(AS_CYC);
            ST_ADDR_HOLD:  timer_len = CNT_W'(AH_CYC);
            ST_RD_TURN:    timer_len = CNT_W'(GAP_CYC);
            ST_RD_STROBE:  timer_len = CNT_W'(OEA_CYC);
            ST_WR_SETUP:   timer_len = CNT_W'(GAP_CYC);
            ST_WR_STROBE:  timer_len = CNT_W'(WP_CYC);
            ST_WR_HOLD:    timer_len = CNT_W'(DH_CYC);
            ST_RECOVER:    timer_len = CNT_W'(REC_CYC);
            default:       timer_len = CNT_W'(1);
        endcase
    end

    assign timer_start = (state_d != state_q);
    assign rd_done     = (state_q == ST_RD_STROBE) && timer_last;
    assign wr_done     = (state_q == ST_WR_STROBE) && timer_last;

    // Pin values decoded from the state being entered.
    always_comb begin
        ce_n_d = 1'b1;
        oe_n_d = 1'b1;
        we_n_d = 1'b1;
        drv_d  = 1'b0;
        out_d  = '0;
        unique case (state_d)
            ST_ADDR_SETUP: begin
                drv_d = 1'b1;
                out_d = nxt_addr;
            end
            ST_ADDR_HOLD: begin
                ce_n_d = 1'b0;
                drv_d  = 1'b1;
                out_d  = nxt_addr;
            end
            ST_RD_TURN: begin
                ce_n_d = 1'b0;
            end
            ST_RD_STROBE: begin
                ce_n_d = 1'b0;
                oe_n_d = 1'b0;
            end
            ST_WR_SETUP: begin
                ce_n_d = 1'b0;
                drv_d  = 1'b1;
                out_d  = wdata_q;
            end
            ST_WR_STROBE: begin
                ce_n_d = 1'b0;
                we_n_d = 1'b0;
                drv_d  = 1'b1;
                out_d  = wdata_q;
            end
            ST_WR_HOLD: begin
                drv_d = 1'b1;
                out_d = wdata_q;
            end
            default: ;
        endcase
    end

    // Registered pin outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n   <= 1'b1;
            oe_n   <= 1'b1;
            we_n   <= 1'b1;
            ad_drv <= 1'b0;
            ad_out <= '0;
        end else begin
            ce_n   <= ce_n_d;
            oe_n   <= oe_n_d;
            we_n   <= we_n_d;
            ad_drv <= drv_d;
            ad_out <= out_d;
        end
    end

    // Interval counters seen on the pins, for the checks below.
    logic [7:0] ce_lo_cnt, hi_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_lo_cnt <= '0;
            hi_cnt    <= '0;
        end else begin
            if (ce_n)                      ce_lo_cnt <= '0;
            else if (ce_lo_cnt != 8'hFF)   ce_lo_cnt <= ce_lo_cnt + 8'd1;
            if (!(ce_n && oe_n && we_n))   hi_cnt    <= '0;
            else if (hi_cnt != 8'hFF)      hi_cnt    <= hi_cnt + 8'd1;
        end
    end

    // R4
    ce_to_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(oe_n) || $fell(we_n)) |-> (int'(ce_lo_cnt) + 1 >= COE_CYC))
        else $error("strobe fell too soon after enable");

    // R8
    rec_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ce_n) |-> (int'(hi_cnt) + 1 >= REC_CYC))
        else $error("recovery gap too short");

    // R5
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !ad_drv)
        else $error("host drives bus while memory output enabled");

    // R9
    rd_we_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> we_n)
        else $error("write strobe low during read");

    // R9
    wr_oe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> oe_n)
        else $error("output enable low during write");

    // R3
    addr_at_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ce_n) |-> ad_drv)
        else $error("address not driven when enable fell");

    // R10
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> !req_ready)
        else $error("ready stayed high after acceptance");

endmodule

// File: rtl/mbus_cycle_ctrl.sv
module mbus_cycle_ctrl
    import mbus_cyc_pkg::*;
#(
    parameter int BUS_W     = 8,
    parameter int CLK_NS    = 10,
    parameter int T_AS_NS   = 5,
    parameter int T_AH_NS   = 25,
    parameter int T_COE_NS  = 25,
    parameter int T_OEA_NS  = 50,
    parameter int T_WP_NS   = 50,
    parameter int T_DH_NS   = 10,
    parameter int T_REC_NS  = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [BUS_W-1:0] req_addr,
    input  logic [BUS_W-1:0] req_wdata,
    output logic             rsp_valid,
    output logic [BUS_W-1:0] rsp_rdata,
    output logic             mem_ce_n,
    output logic             mem_oe_n,
    output logic             mem_we_n,
    output logic [BUS_W-1:0] mem_ad_out,
    output logic             mem_ad_oe,
    input  logic [BUS_W-1:0] mem_ad_in
);

    localparam int AS_CYC  = ns_to_cyc(T_AS_NS,  CLK_NS);
    localparam int AH_CYC  = ns_to_cyc(T_AH_NS,  CLK_NS);
    localparam int COE_CYC = ns_to_cyc(T_COE_NS, CLK_NS);
    localparam int OEA_CYC = ns_to_cyc(T_OEA_NS, CLK_NS);
    localparam int WP_CYC  = ns_to_cyc(T_WP_NS,  CLK_NS);
    localparam int DH_CYC  = ns_to_cyc(T_DH_NS,  CLK_NS);
    localparam int REC_CYC = ns_to_cyc(T_REC_NS, CLK_NS);
    localparam int GAP_CYC = imax(COE_CYC - AH_CYC, 1);
    localparam int MAX_CYC = imax(imax(imax(AS_CYC, AH_CYC), imax(GAP_CYC, OEA_CYC)),
                                  imax(imax(WP_CYC, DH_CYC), REC_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic             t_start, t_last;
    logic [CNT_W-1:0] t_len;
    logic             rd_done, wr_done;

    mbus_seq #(
        .BUS_W  (BUS_W),
        .CNT_W  (CNT_W),
        .AS_CYC (AS_CYC),
        .AH_CYC (AH_CYC),
        .GAP_CYC(GAP_CYC),
        .COE_CYC(COE_CYC),
        .OEA_CYC(OEA_CYC),
        .WP_CYC (WP_CYC),
        .DH_CYC (DH_CYC),
        .REC_CYC(REC_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_ready  (req_ready),
        .timer_last (t_last),
        .timer_start(t_start),
        .timer_len  (t_len),
        .rd_done    (rd_done),
        .wr_done    (wr_done),
        .ce_n       (mem_ce_n),
        .oe_n       (mem_oe_n),
        .we_n       (mem_we_n),
        .ad_out     (mem_ad_out),
        .ad_drv     (mem_ad_oe)
    );

    mbus_phase_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(t_start),
        .len  (t_len),
        .last (t_last)
    );

    mbus_rd_capture #(
        .BUS_W(BUS_W)
    ) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_done  (rd_done),
        .wr_done  (wr_done),
        .bus_in   (mem_ad_in),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata)
    );

endmodule

// File: tb/mbus_cycle_ctrl_test.sv
module mbus_cycle_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    function automatic int to_cyc(input int ns);
        int c;
        c = (ns + CLK_PERIOD - 1) / CLK_PERIOD;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int E_AS  = to_cyc(5);
    localparam int E_AH  = to_cyc(25);
    localparam int E_COE = to_cyc(25);
    localparam int E_OEA = to_cyc(50);
    localparam int E_WP  = to_cyc(50);
    localparam int E_DH  = to_cyc(10);
    localparam int E_REC = to_cyc(20);
    localparam int E_GAP = (E_COE - E_AH > 1) ? (E_COE - E_AH) : 1;
    localparam int E_RD_BUSY = E_AS + E_AH + E_GAP + E_OEA + E_REC;
    localparam int E_WR_BUSY = E_AS + E_AH + E_GAP + E_WP + E_DH + E_REC;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid, req_ready, req_write;
    logic [W-1:0] req_addr, req_wdata;
    logic         rsp_valid;
    logic [W-1:0] rsp_rdata;
    logic         ce_n, oe_n, we_n, ad_oe;
    logic [W-1:0] ad_out, ad_in;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mbus_cycle_ctrl #(
        .BUS_W(W), .CLK_NS(CLK_PERIOD), .T_AS_NS(5), .T_AH_NS(25), .T_COE_NS(25),
        .T_OEA_NS(50), .T_WP_NS(50), .T_DH_NS(10), .T_REC_NS(20)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_ce_n(ce_n),
        .mem_oe_n(oe_n), .mem_we_n(we_n), .mem_ad_out(ad_out),
        .mem_ad_oe(ad_oe), .mem_ad_in(ad_in)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Memory device model and expected contents.
    logic [W-1:0] dev_mem [256];
    logic [W-1:0] shadow  [256];
    logic [W-1:0] lat_addr = '0;

    initial begin
        for (int i = 0; i < 256; i++) begin
            dev_mem[i] = W'(i * 3 + 7);
            shadow[i]  = W'(i * 3 + 7);
        end
    end

    always_comb ad_in = (!ce_n && !oe_n) ? dev_mem[lat_addr] : 8'hEE;

    typedef struct packed { logic wr; logic [W-1:0] data; } exp_t;
    exp_t sbq[$];

    // Pin monitor and scoreboard.
    bit p_ce = 1, p_oe = 1, p_we = 1, p_drv = 0, p_rsp = 0, in_dh = 0;
    int as_run = 0, hold_run = 0, ce_lo = 0, oe_lo = 0, we_lo = 0, dh_run = 0, hi_run = 0;
    logic [W-1:0] p_out = '0, wr_val = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_ce && !ce_n) begin
                chk(as_run >= E_AS, "R2", "address setup cycles", as_run, E_AS);
                chk(ad_oe, "R3", "address driven at enable fall", int'(ad_oe), 1);
                chk(hi_run >= E_REC, "R8", "recovery cycles", hi_run, E_REC);
                lat_addr = ad_out;
                hold_run = 0;
                ce_lo = 0;
            end
            if (p_oe && !oe_n) begin
                chk(ce_lo >= E_COE, "R4", "enable to output strobe", ce_lo, E_COE);
                chk(hold_run >= E_AH, "R3", "address hold cycles", hold_run, E_AH);
                chk(!p_drv && !ad_oe, "R5", "bus released before read strobe",
                    int'(p_drv) + int'(ad_oe), 0);
                chk(we_n, "R9", "write strobe high in read", int'(we_n), 1);
                oe_lo = 0;
            end
            if (p_we && !we_n) begin
                chk(ce_lo >= E_COE, "R4", "enable to write strobe", ce_lo, E_COE);
                chk(hold_run >= E_AH, "R3", "address hold cycles", hold_run, E_AH);
                chk(oe_n, "R9", "output strobe high in write", int'(oe_n), 1);
                chk(ad_oe, "R7", "data driven at write strobe", int'(ad_oe), 1);
                we_lo = 0;
            end
            if (!p_oe && oe_n) begin
                chk(oe_lo == E_OEA, "R6", "output strobe width", oe_lo, E_OEA);
                chk(ce_n, "R6", "enable rises with output strobe", int'(ce_n), 1);
                chk(rsp_valid, "R6", "response after read", int'(rsp_valid), 1);
            end
            if (!p_we && we_n) begin
                chk(we_lo >= E_WP, "R7", "write pulse width", we_lo, E_WP);
                chk(ce_n, "R7", "enable rises with write strobe", int'(ce_n), 1);
                chk(rsp_valid, "R11", "response after write", int'(rsp_valid), 1);
                dev_mem[lat_addr] = p_out;
                wr_val = p_out;
                in_dh = 1;
                dh_run = 0;
            end
            if (in_dh && !(ad_oe && ad_out == wr_val)) begin
                chk(dh_run >= E_DH, "R7", "write data hold", dh_run, E_DH);
                in_dh = 0;
            end
            if (!ce_n && !oe_n && ad_oe)
                chk(0, "R5", "bus contention", 1, 0);
            if (!oe_n && !we_n)
                chk(0, "R9", "both strobes low", 0, 1);
            if (rsp_valid) begin
                chk(!p_rsp, "R6", "response pulse length", 2, 1);
                if (sbq.size() == 0) begin
                    chk(0, "R10", "unexpected response", 1, 0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    if (!e.wr)
                        chk(rsp_rdata == e.data, "R6", "read data",
                            int'(rsp_rdata), int'(e.data));
                end
            end
            // Interval counters.
            as_run = (ce_n && ad_oe) ? as_run + 1 : 0;
            if (!ce_n && ad_oe && ad_out == lat_addr && oe_n && we_n) hold_run++;
            if (!ce_n) ce_lo++;
            if (!oe_n) oe_lo++;
            if (!we_n) we_lo++;
            if (in_dh) dh_run++;
            hi_run = (ce_n && oe_n && we_n) ? hi_run + 1 : 0;
        end
        p_ce = ce_n; p_oe = oe_n; p_we = we_n; p_drv = ad_oe;
        p_rsp = rsp_valid; p_out = ad_out;
    end

    // Driver: issues one access and pushes its expected result.
    task automatic issue(input bit wr, input logic [W-1:0] a, input logic [W-1:0] d);
        int busy;
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        e.wr   = wr;
        e.data = wr ? d : shadow[a];
        sbq.push_back(e);
        if (wr) shadow[a] = d;
        @(negedge clk);
        chk(!req_ready, "R10", "ready low after acceptance", int'(req_ready), 0);
        // A conflicting request while busy must be ignored (R10).
        req_addr  = ~a;
        req_write = ~wr;
        req_wdata = ~d;
        busy = 1;
        @(negedge clk);
        if (!req_ready) busy++;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) begin
            busy++;
            @(negedge clk);
        end
        chk(busy == (wr ? E_WR_BUSY : E_RD_BUSY), "R10", "busy cycles", busy,
            wr ? E_WR_BUSY : E_RD_BUSY);
    endtask

    bit done = 0;

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr = '0;
        req_wdata = '0;
        repeat (3) @(negedge clk);
        chk(req_ready, "R1", "ready in reset", int'(req_ready), 1);
        chk(ce_n && oe_n && we_n, "R1", "strobes in reset",
            int'({ce_n, oe_n, we_n}), 7);
        chk(!ad_oe, "R1", "drive enable in reset", int'(ad_oe), 0);
        chk(!rsp_valid, "R1", "response in reset", int'(rsp_valid), 0);
        rst_n = 1'b1;

        issue(1'b1, 8'h00, 8'hA5);
        issue(1'b0, 8'h00, 8'h00);
        issue(1'b1, 8'hFF, 8'h3C);
        issue(1'b0, 8'hFF, 8'h00);
        issue(1'b0, 8'h42, 8'h00);
        issue(1'b1, 8'h42, 8'h42);
        issue(1'b0, 8'h42, 8'h00);
        issue(1'b1, 8'h80, 8'hFF);
        issue(1'b1, 8'h81, 8'h00);
        issue(1'b0, 8'h80, 8'h00);
        issue(1'b0, 8'h81, 8'h00);
        for (int k = 0; k < 6; k++) begin
            issue(1'b1, 8'(k * 37 + 5), 8'(k * 29 + 1));
            issue(1'b0, 8'(k * 37 + 5), 8'h00);
        end
        issue(1'b0, 8'h7E, 8'h00);
        repeat (20) @(negedge clk);
        chk(sbq.size() == 0, "R10", "outstanding responses", sbq.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        done = 1;
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule